// File: doc/BRIEF.md
# TDM Bit-Delay Reformatter

This block re-times an eight-slot TDM serial stream so that a receiver expecting delay-by-one framing can accept it without loss. The upstream source places each slot's MSB on the first bit time after the frame clock rises, which is left-justified, zero-delay framing. The block passes the frame clock through with one bit time of latency. It delays the serial data by one further bit time, so on the output every MSB follows its frame edge by exactly one bit clock.

The whole block runs on the incoming bit clock. Inputs are sampled on the rising edge and outputs are launched on the falling edge, so a downstream port sampling on the rising edge sees stable data. A position counter follows the frame and exposes the current slot and bit number for debug. A sticky error flag reports any frame whose length is not the nominal one.

Top module: `tdm_delay_fmt`

## Requirements
- R1: After reset, `fs_out`, `sd_out` and `frame_err` are 0. `sd_out` stays 0 until a rising edge of `fs_in` has been sampled after reset.
- R2: `fs_out` during bit time t equals `fs_in` during bit time t-1. There is exactly one bit time of latency, and the frame clock is otherwise unchanged.
- R3: Once a rising frame edge has been sampled at or before bit time t-1, `sd_out` during bit time t equals `sd_in` during bit time t-2. The output MSB of slot 0 therefore lies one bit time after the rising edge of `fs_out`, and the previous frame's last LSB occupies the edge bit time.
- R4: The active frame edge is a rising `fs_in`. The input bit sampled together with that edge has position 0. After each sampled input bit, `slot_idx` is position/32 (3 bits) and `bit_idx` is position mod 32 (5 bits, 0 = MSB).
- R5: `frame_err` is set when a rising frame edge arrives after an earlier one and the number of bit times between the two edges differs from 256, whether the frame is short or long.
- R6: `frame_err` is sticky. It is cleared by `err_clr` sampled high on a rising bit-clock edge, and a new error in the same cycle takes priority over the clear.
- R7: The first frame edge after reset never sets `frame_err`, and frames of exactly 256 bit times never set it.
- R8: A falling edge of `fs_in` (the 50% duty midpoint at position 128) does not restart the position count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit clock; inputs sampled on rising edge, outputs launched on falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| err_clr | input | 1 | Synchronous clear of the sticky frame error |
| fs_in | input | 1 | Frame clock from the left-justified source |
| sd_in | input | 1 | Serial data from the source, MSB first |
| fs_out | output | 1 | Re-timed frame clock |
| sd_out | output | 1 | Serial data in delay-by-one framing |
| slot_idx | output | 3 | Slot number of the last sampled input bit |
| bit_idx | output | 5 | Bit number within the slot of the last sampled input bit |
| frame_err | output | 1 | Sticky flag for an off-length frame |

## Verification
A slip in the data delay register shows up on `sd_out` within the next bit time. The stream is then one position off from the input two bit times earlier, so every slot's MSB lands on the wrong clock. A position counter that restarts on the wrong edge, or fails to restart, shows in `slot_idx`/`bit_idx` on the bit right after the event. It also leads to a spurious or missing `frame_err` at the next frame edge, at most 256 bit times later. A lock state that never engages keeps `sd_out` silent through the whole first frame.

// File: rtl/tdm_fmt_pkg.sv
// Shared defaults and types for the TDM bit-delay reformatter.
// Assumes slot count and slot width are powers of two.
package tdm_fmt_pkg;
    localparam int DEF_SLOTS     = 8;
    localparam int DEF_SLOT_BITS = 32;

    // Tracking state: hunting for the first frame edge, or following frames
    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_st_t;
endpackage

// File: rtl/tdm_frame_track.sv
// Frame tracker: detects the rising frame edge, counts bit positions
// inside the frame, records lock after the first edge and keeps a sticky
// flag for frames of the wrong length.
// Assumes fs_last is fs_now delayed by one rising bit-clock edge.
module tdm_frame_track
    import tdm_fmt_pkg::*;
#(
    parameter int SLOTS     = DEF_SLOTS,
    parameter int SLOT_BITS = DEF_SLOT_BITS,
    localparam int FRAME_BITS = SLOTS * SLOT_BITS,
    localparam int CNT_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk_bit,
    input  logic             rst_n,
    input  logic             fs_now,
    input  logic             fs_last,
    input  logic             err_clr,
    output logic [CNT_W-1:0] pos,
    output logic             locked,
    output logic             frame_err
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

    lock_st_t st;
    logic     ovr;
    logic     edge_hit;
    logic     len_bad;

    assign edge_hit = fs_now & ~fs_last;
    assign len_bad  = (pos != LAST_POS) | ovr;
    assign locked   = (st == ST_LOCKED);

    // Position counter, overrun marker and lock state
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            pos <= '0;
            ovr <= 1'b0;
            st  <= ST_HUNT;
        end else if (edge_hit) begin
            pos <= '0;
            ovr <= 1'b0;
            st  <= ST_LOCKED;
        end else if (pos == LAST_POS) begin
            pos <= '0;
            ovr <= 1'b1;
        end else begin
            pos <= pos + 1'b1;
        end
    end

    // Sticky frame-length error; a new error wins over a clear
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            frame_err <= 1'b0;
        end else if (edge_hit && locked && len_bad) begin
            frame_err <= 1'b1;
        end else if (err_clr) begin
            frame_err <= 1'b0;
        end
    end
endmodule

// File: rtl/tdm_bit_delay.sv
// Data path: samples frame clock and data on the rising bit-clock edge,
// holds data one extra bit time, and launches frame clock and delayed data
// on the falling edge. Data output is gated off until the tracker locks.
module tdm_bit_delay (
    input  logic clk_bit,
    input  logic rst_n,
    input  logic fs_in,
    input  logic sd_in,
    input  logic gate_open,
    output logic fs_held,
    output logic fs_out,
    output logic sd_out
);
    logic sd_q;
    logic sd_qq;

    // Capture stage plus the one-bit data delay register
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            fs_held <= 1'b0;
            sd_q    <= 1'b0;
            sd_qq   <= 1'b0;
        end else begin
            fs_held <= fs_in;
            sd_q    <= sd_in;
            sd_qq   <= sd_q;
        end
    end

    // Launch stage on the falling edge, as the receiver expects
    always_ff @(negedge clk_bit) begin
        if (!rst_n) begin
            fs_out <= 1'b0;
            sd_out <= 1'b0;
        end else begin
            fs_out <= fs_held;
            sd_out <= sd_qq & gate_open;
        end
    end
endmodule

// File: rtl/tdm_delay_fmt.sv
// Top: converts a left-justified TDM stream to delay-by-one framing.
// The frame clock gains one bit of latency; the data gains two, so each
// MSB moves one bit time behind its frame edge. Debug position outputs
// describe the most recently sampled input bit.
// Assumes SLOTS and SLOT_BITS are powers of two.
module tdm_delay_fmt
    import tdm_fmt_pkg::*;
#(
    parameter int SLOTS     = DEF_SLOTS,
    parameter int SLOT_BITS = DEF_SLOT_BITS,
    localparam int FRAME_BITS = SLOTS * SLOT_BITS,
    localparam int CNT_W      = $clog2(FRAME_BITS),
    localparam int SLOT_W     = $clog2(SLOTS),
    localparam int BIT_W      = $clog2(SLOT_BITS)
) (
    input  logic              clk_bit,
    input  logic              rst_n,
    input  logic              err_clr,
    input  logic              fs_in,
    input  logic              sd_in,
    output logic              fs_out,
    output logic              sd_out,
    output logic [SLOT_W-1:0] slot_idx,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              frame_err
);
    logic             fs_held;
    logic             locked;
    logic [CNT_W-1:0] pos;

    tdm_bit_delay u_delay (
        .clk_bit   (clk_bit),
        .rst_n     (rst_n),
        .fs_in     (fs_in),
        .sd_in     (sd_in),
        .gate_open (locked),
        .fs_held   (fs_held),
        .fs_out    (fs_out),
        .sd_out    (sd_out)
    );

    tdm_frame_track #(
        .SLOTS     (SLOTS),
        .SLOT_BITS (SLOT_BITS)
    ) u_track (
        .clk_bit   (clk_bit),
        .rst_n     (rst_n),
        .fs_now    (fs_in),
        .fs_last   (fs_held),
        .err_clr   (err_clr),
        .pos       (pos),
        .locked    (locked),
        .frame_err (frame_err)
    );

    assign slot_idx = pos[CNT_W-1 -: SLOT_W];
    assign bit_idx  = pos[BIT_W-1:0];
endmodule

// File: rtl/tdm_delay_fmt_chk.sv
// Checker for the reformatter: timing of the re-timed outputs, position
// tracking and error flag rules. Attached to the top with bind below.
module tdm_delay_fmt_chk #(
    parameter int SLOTS     = 8,
    parameter int SLOT_BITS = 32,
    localparam int FRAME_BITS = SLOTS * SLOT_BITS,
    localparam int CNT_W      = $clog2(FRAME_BITS),
    localparam int SLOT_W     = $clog2(SLOTS),
    localparam int BIT_W      = $clog2(SLOT_BITS)
) (
    input logic              clk_bit,
    input logic              rst_n,
    input logic              err_clr,
    input logic              fs_in,
    input logic              sd_in,
    input logic              fs_out,
    input logic              sd_out,
    input logic [SLOT_W-1:0] slot_idx,
    input logic [BIT_W-1:0]  bit_idx,
    input logic              frame_err,
    input logic              locked
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

    logic             fs_d;
    logic [1:0]       age;
    logic             edge_c;
    logic [CNT_W-1:0] pos_c;

    assign edge_c = fs_in & ~fs_d;
    assign pos_c  = {slot_idx, bit_idx};

    // Own copy of the previous frame clock and cycles since reset
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            fs_d <= 1'b0;
            age  <= 2'd0;
        end else begin
            fs_d <= fs_in;
            if (age != 2'd3) age <= age + 2'd1;
        end
    end

    AST_QUIET_UNTIL_LOCK: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !locked |-> !sd_out); // R1
    AST_FS_ONE_BIT: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (age != 2'd0) |-> (fs_out == $past(fs_in))); // R2
    AST_SD_TWO_BIT: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (age == 2'd3 && locked) |-> (sd_out == $past(sd_in, 2))); // R3
    AST_POS_RESTART: assert property (@(posedge clk_bit) disable iff (!rst_n)
        edge_c |=> (pos_c == '0)); // R4
    AST_POS_STEP: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !edge_c |=> (pos_c == (($past(pos_c) == LAST_POS) ? '0 : $past(pos_c) + 1'b1))); // R8
    AST_ERR_SHORT: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (edge_c && locked && pos_c != LAST_POS) |=> frame_err); // R5
    AST_ERR_STICKY: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (frame_err && !err_clr) |=> frame_err); // R6
    AST_ERR_CLEAR: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (err_clr && !(edge_c && locked)) |=> !frame_err); // R6
    AST_HUNT_NO_ERR: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (!locked && !frame_err) |=> !frame_err); // R7
endmodule

bind tdm_delay_fmt tdm_delay_fmt_chk #(
    .SLOTS     (SLOTS),
    .SLOT_BITS (SLOT_BITS)
) u_chk (
    .clk_bit   (clk_bit),
    .rst_n     (rst_n),
    .err_clr   (err_clr),
    .fs_in     (fs_in),
    .sd_in     (sd_in),
    .fs_out    (fs_out),
    .sd_out    (sd_out),
    .slot_idx  (slot_idx),
    .bit_idx   (bit_idx),
    .frame_err (frame_err),
    .locked    (locked)
);

// File: tb/tdm_delay_fmt_tb.sv
// Bench for the reformatter: random payload with directed frame lengths,
// clear timing and bit patterns, checked against a bit-time reference model.
module tdm_delay_fmt_tb_top;
    localparam int FRAME = 256;

    logic       clk_bit = 1'b0;
    logic       rst_n;
    logic       err_clr;
    logic       fs_in;
    logic       sd_in;
    logic       fs_out;
    logic       sd_out;
    logic [2:0] slot_idx;
    logic [4:0] bit_idx;
    logic       frame_err;

    int n_run  = 0;
    int n_fail = 0;

    // Reference model state, in bit times
    bit m_prev_fs = 1'b0;
    bit m_d1      = 1'b0;
    bit m_d2      = 1'b0;
    bit m_seen    = 1'b0;
    bit m_err     = 1'b0;
    int m_since   = 0;

    always #5 clk_bit = ~clk_bit;

    tdm_delay_fmt dut_i (
        .clk_bit   (clk_bit),
        .rst_n     (rst_n),
        .err_clr   (err_clr),
        .fs_in     (fs_in),
        .sd_in     (sd_in),
        .fs_out    (fs_out),
        .sd_out    (sd_out),
        .slot_idx  (slot_idx),
        .bit_idx   (bit_idx),
        .frame_err (frame_err)
    );

    function automatic bit exp_err(bit is_edge, bit clr, int len);
        if (is_edge && m_seen && len != FRAME) return 1'b1;
        if (clr) return 1'b0;
        return m_err;
    endfunction

    task automatic check(string req, int act, int exp, string what);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // One bit time: drive on the falling edge, check after the rising edge
    task automatic drive_bit(bit fs, bit sd, bit clr);
        bit is_edge;
        int len;
        @(negedge clk_bit);
        fs_in   = fs;
        sd_in   = sd;
        err_clr = clr;
        @(posedge clk_bit);
        #1;
        is_edge = fs && !m_prev_fs;
        check("R2", int'(fs_out), int'(m_prev_fs), "fs_out");
        if (m_seen) check("R3", int'(sd_out), int'(m_d2), "sd_out");
        else        check("R1", int'(sd_out), 0, "sd_out before lock");
        len     = m_since + 1;
        m_err   = exp_err(is_edge, clr, len);
        m_since = is_edge ? 0 : len;
        if (is_edge) m_seen = 1'b1;
        if (m_seen && m_since < FRAME) begin
            check("R4 R8", int'(slot_idx), m_since / 32, "slot_idx");
            check("R4 R8", int'(bit_idx), m_since % 32, "bit_idx");
        end
        check("R5 R6 R7", int'(frame_err), int'(m_err), "frame_err");
        m_d2      = m_d1;
        m_d1      = sd;
        m_prev_fs = fs;
    endtask

    // One frame: mode 0 random, 1 only slot-0 MSB set, 2 all ones
    task automatic frame(int len, int mode, int clr_at);
        for (int i = 0; i < len; i++) begin
            bit d;
            case (mode)
                1:       d = (i == 0);
                2:       d = 1'b1;
                default: d = 1'($urandom % 2);
            endcase
            drive_bit(i < len / 2, d, i == clr_at);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk_bit);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        rst_n   = 1'b0;
        err_clr = 1'b0;
        fs_in   = 1'b0;
        sd_in   = 1'b0;
        repeat (4) @(posedge clk_bit);
        #1;
        check("R1", int'(fs_out), 0, "fs_out in reset");
        check("R1", int'(sd_out), 0, "sd_out in reset");
        check("R1", int'(frame_err), 0, "frame_err in reset");
        rst_n = 1'b1;
        // R1: random data before any frame edge stays off the output
        for (int i = 0; i < 20; i++) drive_bit(1'b0, 1'($urandom % 2), 1'b0);
        // R3: lone MSB marker, then all ones, then random frames (R7, R8)
        frame(FRAME, 1, -1);
        frame(FRAME, 2, -1);
        frame(FRAME, 0, -1);
        frame(FRAME, 0, -1);
        // R5: short frame, error raised at the next edge; R6 sticky
        frame(200, 0, -1);
        frame(FRAME, 0, -1);
        frame(FRAME, 0, 40);
        // R5: long frame past the counter wrap; R6 error beats clear at edge
        frame(300, 0, -1);
        frame(FRAME, 1, 0);
        frame(FRAME, 0, 10);
        frame(FRAME, 2, -1);
        drive_bit(1'b1, 1'b0, 1'b0);
        drive_bit(1'b1, 1'b0, 1'b0);
        summary();
        $finish;
    end
endmodule